// File: doc/BRIEF.md
# Word-Aligned Instruction Fetch Unit

This block produces the program counter and the instruction word for a 32-bit processor that completes each instruction in one clock. The counter is stored only at word granularity: it holds the 30 upper address bits, and the byte fetch address presented to the instruction memory is that count with two zero bits appended. Every clock edge moves the counter to one of three successors: the next sequential word, a PC-relative branch target, or an absolute jump target.

Each cycle the surrounding core decodes the instruction word. It then returns a branch request, the zero flag from its execution unit, a jump request and the same instruction word. From these the block selects and registers the next count. Branch offsets and jump targets are formed directly in word units, so no shift stage sits on the next-address path. A small internal instruction memory of 256 words is indexed by the low counter bits and read without a clock. It is loaded through a simple write port.

Top module: `word_fetch_unit`

## Requirements
- R1: The fetch address is always the 30-bit word counter followed by two zero bits, so fetchAddr[1:0] is always 0.
- R2: When jumpReq is 0 and a branch is not taken, the fetch address after the clock edge is the previous fetch address plus 4.
- R3: When branchReq is 1, zeroFlag is 1 and jumpReq is 0, the next word count is the current count plus one plus instrIn[15:0], sign-extended to 30 bits. In byte terms this is fetchAddr + 4 + 4*sext(instrIn[15:0]).
- R4: When branchReq is 1 and zeroFlag is 0, the branch request has no effect and the unit steps sequentially, as in R2.
- R5: When jumpReq is 1, the next fetch address is {fetchAddr[31:28], instrIn[25:0], 2'b00}, where fetchAddr[31:28] is taken before the edge.
- R6: When jumpReq and a taken branch (branchReq=1, zeroFlag=1) are requested together, the jump wins and the target is as in R5.
- R7: When rst is 1 at a rising clock edge, the counter becomes zero, so fetchAddr reads 0 after that edge. This takes priority over all other controls.
- R8: instrOut shows, without a clock, the memory word at index fetchAddr[9:2]. With memWrEn=1 at a rising edge, memWrData is stored at word index memWrIdx, and that value is visible on instrOut from the same edge onward.
- R9: All counter arithmetic wraps modulo 2^30 words without any flag. From address 0, a branch with offset -2 lands on 0xFFFFFFFC, and a sequential step from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branchReq | input | 1 | Conditional branch request from the decoder |
| zeroFlag | input | 1 | Zero result from the execution unit; qualifies branchReq |
| jumpReq | input | 1 | Absolute jump request from the decoder |
| instrIn | input | 32 | Current instruction word; bits 15:0 give the branch offset, bits 25:0 the jump field |
| memWrEn | input | 1 | Write strobe for the instruction memory |
| memWrIdx | input | 8 | Word index written when memWrEn is 1 |
| memWrData | input | 32 | Word stored when memWrEn is 1 |
| fetchAddr | output | 32 | Byte fetch address; low two bits are zero |
| instrOut | output | 32 | Instruction word at the current fetch address |

## Verification
The main sweep cycles through all eight combinations of branchReq, zeroFlag and jumpReq, with offsets and jump fields drawn from a pseudo-random stream. Sequential steps, taken branches, suppressed branches and jumps are each compared against an arithmetic model of the word counter. The combinations where the jump and a taken branch are requested together show whether the priority is right, and branchReq with zeroFlag at 0 shows whether the flag really qualifies the branch. Directed offsets of 0, +1, 0x7FFF, 0x8000 and -2 starting from address 0 check sign extension and the wrap at both ends of the address space. Reading the preloaded words back at every step, plus one rewrite of the word currently addressed, tests the memory index and write timing.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Source chosen for the next counter value
  typedef enum logic [1:0] {
    NEXT_SEQ    = 2'd0,
    NEXT_BRANCH = 2'd1,
    NEXT_JUMP   = 2'd2
  } nextSel_t;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic     clearPc;
    nextSel_t nextSel;
  } fetchStrobes_t;

endpackage

// File: rtl/fetch_control.sv
module fetch_control
  import fetch_pkg::*;
(
  input  logic          rst,
  input  logic          branchReq,
  input  logic          zeroFlag,
  input  logic          jumpReq,
  output fetchStrobes_t strobes
);

  logic branchTaken;

  assign branchTaken = branchReq & zeroFlag;

  always_comb begin
    strobes.clearPc = rst;
    if (jumpReq)
      strobes.nextSel = NEXT_JUMP;      // jump outranks a taken branch
    else if (branchTaken)
      strobes.nextSel = NEXT_BRANCH;
    else
      strobes.nextSel = NEXT_SEQ;       // an untaken branch falls through
  end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int CNT_W  = 30,
  parameter int IMM_W  = 16,
  parameter int JUMP_W = 26
) (
  input  logic              clk,
  input  fetchStrobes_t     strobes,
  input  logic [IMM_W-1:0]  branchOfs,
  input  logic [JUMP_W-1:0] jumpField,
  output logic [CNT_W-1:0]  pcWord
);

  localparam int KEEP_W = CNT_W - JUMP_W;
  localparam int EXT_W  = CNT_W - IMM_W;

  logic [CNT_W-1:0] pcInc;
  logic [CNT_W-1:0] ofsWide;
  logic [CNT_W-1:0] branchTarget;
  logic [CNT_W-1:0] jumpTarget;
  logic [CNT_W-1:0] pcNext;

  // word-unit arithmetic, wrapping at 2^CNT_W
  assign pcInc        = pcWord + {{(CNT_W-1){1'b0}}, 1'b1};
  assign ofsWide      = {{EXT_W{branchOfs[IMM_W-1]}}, branchOfs};
  assign branchTarget = pcInc + ofsWide;

  generate
    if (KEEP_W > 0) begin : g_keepUpper
      assign jumpTarget = {pcWord[CNT_W-1:JUMP_W], jumpField};
    end else begin : g_fullJump
      assign jumpTarget = jumpField[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (strobes.nextSel)
      NEXT_JUMP:   pcNext = jumpTarget;
      NEXT_BRANCH: pcNext = branchTarget;
      default:     pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.clearPc)
      pcWord <= '0;
    else
      pcWord <= pcNext;
  end

endmodule

// File: rtl/instr_store.sv
module instr_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn)
      words[wrIdx] <= wrData;
  end

  assign rdData = words[rdIdx];

endmodule

// File: rtl/word_fetch_unit.sv
module word_fetch_unit
  import fetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_W   = 2,
  parameter int IMM_W     = 16,
  parameter int JUMP_W    = 26,
  parameter int MEM_DEPTH = 256,
  localparam int CNT_W    = ADDR_W - ALIGN_W,
  localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branchReq,
  input  logic              zeroFlag,
  input  logic              jumpReq,
  input  logic [ADDR_W-1:0] instrIn,
  input  logic              memWrEn,
  input  logic [IDX_W-1:0]  memWrIdx,
  input  logic [ADDR_W-1:0] memWrData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] instrOut
);

  fetchStrobes_t    strobes;
  logic [CNT_W-1:0] pcWord;

  fetch_control u_control (
    .rst       (rst),
    .branchReq (branchReq),
    .zeroFlag  (zeroFlag),
    .jumpReq   (jumpReq),
    .strobes   (strobes)
  );

  fetch_datapath #(
    .CNT_W  (CNT_W),
    .IMM_W  (IMM_W),
    .JUMP_W (JUMP_W)
  ) u_datapath (
    .clk       (clk),
    .strobes   (strobes),
    .branchOfs (instrIn[IMM_W-1:0]),
    .jumpField (instrIn[JUMP_W-1:0]),
    .pcWord    (pcWord)
  );

  instr_store #(
    .DATA_W (ADDR_W),
    .DEPTH  (MEM_DEPTH)
  ) u_store (
    .clk    (clk),
    .wrEn   (memWrEn),
    .wrIdx  (memWrIdx),
    .wrData (memWrData),
    .rdIdx  (pcWord[IDX_W-1:0]),
    .rdData (instrOut)
  );

  assign fetchAddr = {pcWord, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/word_fetch_checker.sv
module word_fetch_checker (
  input logic        clk,
  input logic        rst,
  input logic        branchReq,
  input logic        zeroFlag,
  input logic        jumpReq,
  input logic [31:0] instrIn,
  input logic [31:0] fetchAddr
);

  logic [31:0] ofsBytes;
  assign ofsBytes = {{14{instrIn[15]}}, instrIn[15:0], 2'b00};

  // R2 and R4: sequential step, including a branch whose flag is low
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!jumpReq && !(branchReq && zeroFlag)) |=> fetchAddr == $past(fetchAddr) + 32'd4);

  // R3: taken branch adds the scaled offset to the next word
  assert_branch_target_R3: assert property (@(posedge clk) disable iff (rst)
    (!jumpReq && branchReq && zeroFlag) |=>
      fetchAddr == $past(fetchAddr) + 32'd4 + $past(ofsBytes));

  // R5 and R6: jump replaces the low 28 bits, keeps the top nibble
  assert_jump_target_R5: assert property (@(posedge clk) disable iff (rst)
    jumpReq |=> fetchAddr == {$past(fetchAddr[31:28]), $past(instrIn[25:0]), 2'b00});

  // R7: reset clears the counter
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> fetchAddr == 32'd0);

endmodule

bind word_fetch_unit word_fetch_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .branchReq (branchReq),
  .zeroFlag  (zeroFlag),
  .jumpReq   (jumpReq),
  .instrIn   (instrIn),
  .fetchAddr (fetchAddr)
);

// File: tb/test_word_fetch_unit.sv
module test_word_fetch_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        branchReq, zeroFlag, jumpReq;
  logic [31:0] instrIn;
  logic        memWrEn;
  logic [7:0]  memWrIdx;
  logic [31:0] memWrData;
  logic [31:0] fetchAddr, instrOut;

  int          vectors = 0;
  int          misses  = 0;
  bit          finished = 1'b0;
  logic [29:0] expPc;
  logic [31:0] memModel [256];
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;   // 250 MHz

  word_fetch_unit i_word_fetch_unit (
    .clk       (clk),
    .rst       (rst),
    .branchReq (branchReq),
    .zeroFlag  (zeroFlag),
    .jumpReq   (jumpReq),
    .instrIn   (instrIn),
    .memWrEn   (memWrEn),
    .memWrIdx  (memWrIdx),
    .memWrData (memWrData),
    .fetchAddr (fetchAddr),
    .instrOut  (instrOut)
  );

  function automatic logic [31:0] nextRand(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] want);
    vectors++;
    if (got !== want) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  // compare address and read word against the model after an edge
  task automatic checkState(string req);
    check(req, fetchAddr, {expPc, 2'b00});
    check("R1", {30'd0, fetchAddr[1:0]}, 32'd0);
    check("R8", instrOut, memModel[expPc[7:0]]);
  endtask

  // apply controls, clock once, update model, check
  task automatic stepOnce(logic br, logic zf, logic jp, logic [31:0] ins);
    string req;
    branchReq = br; zeroFlag = zf; jumpReq = jp; instrIn = ins;
    if (jp && br && zf) req = "R6";
    else if (jp)        req = "R5";
    else if (br && zf)  req = "R3";
    else if (br)        req = "R4";
    else                req = "R2";
    if (jp)
      expPc = {expPc[29:26], ins[25:0]};
    else if (br && zf)
      expPc = expPc + 30'd1 + {{14{ins[15]}}, ins[15:0]};
    else
      expPc = expPc + 30'd1;
    @(posedge clk);
    @(negedge clk);
    checkState(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; branchReq = 0; zeroFlag = 0; jumpReq = 0; instrIn = '0;
    memWrEn = 0; memWrIdx = '0; memWrData = '0;

    // preload memory while held in reset
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      memModel[i] = (i * 32'h0101_0101) ^ 32'hA5C3_0000;
      memWrEn = 1'b1; memWrIdx = i[7:0]; memWrData = memModel[i];
      @(posedge clk);
      @(negedge clk);
    end
    memWrEn = 1'b0;
    expPc = '0;
    check("R7", fetchAddr, 32'd0);
    checkState("R7");
    rst = 1'b0;

    // R9: wrap below zero and past the top
    stepOnce(1'b1, 1'b1, 1'b0, 32'h0000_FFFE);
    check("R9", fetchAddr, 32'hFFFF_FFFC);
    stepOnce(1'b0, 1'b0, 1'b0, 32'h0);
    check("R9", fetchAddr, 32'h0000_0000);

    // R3 directed offset boundaries
    stepOnce(1'b1, 1'b1, 1'b0, 32'h0000_0000);
    stepOnce(1'b1, 1'b1, 1'b0, 32'h0000_0001);
    stepOnce(1'b1, 1'b1, 1'b0, 32'h0000_7FFF);
    stepOnce(1'b1, 1'b1, 1'b0, 32'h0000_8000);
    stepOnce(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    // R4: branch with a large offset but zero flag low
    stepOnce(1'b1, 1'b0, 1'b0, 32'h0000_7FFF);
    // R6: jump together with taken branch
    stepOnce(1'b1, 1'b1, 1'b1, 32'h03FF_FF00);

    // sweep all control combinations with varied fields
    for (int n = 0; n < 2000; n++) begin
      rng = nextRand(rng);
      stepOnce(n[0], n[1], n[2], rng);
    end

    // R8: rewrite the word currently addressed, visible after the edge
    memWrEn = 1'b1; memWrIdx = expPc[7:0]; memWrData = 32'hDEAD_BEEF;
    memModel[expPc[7:0]] = 32'hDEAD_BEEF;
    branchReq = 0; zeroFlag = 0; jumpReq = 1'b1; instrIn = {6'd0, expPc[25:0]};
    @(posedge clk);
    @(negedge clk);
    memWrEn = 1'b0;
    check("R8", instrOut, 32'hDEAD_BEEF);
    checkState("R5");

    // R7: reset mid-run overrides a jump
    rst = 1'b1; jumpReq = 1'b1; instrIn = 32'h0123_4567;
    @(posedge clk);
    @(negedge clk);
    expPc = '0;
    checkState("R7");
    rst = 1'b0;
    stepOnce(1'b0, 1'b0, 1'b0, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule